// File: doc/BRIEF.md
# Two-Rate Link Speed Negotiation Controller

This block runs the speed negotiation for one end of a point-to-point serial link whose transceiver can run its line at a low rate, a high rate, or both. It drives the transmit-rate and receive-rate selects of that transceiver. While it searches, it transmits at the fastest rate it supports. In the same period it steps its own receive rate through its supported rates, starting with the low one. A good-data indicator comes from outside the block, for example a word-sync or valid-code flag. When that indicator stays high long enough at one receive rate, the controller moves its transmit rate to that rate, raises a locked flag and reports the settled rate.

The result is that two dual-rate nodes end at the high rate, and a dual-rate node facing a low-only peer ends at the low rate. Neither node needs to start at a rate both share. If the link loses good data for a full dwell window after settling, the controller starts the search again from its start-up state.

Timing is set by two parameters. `DWELL_CYCLES` is how many clock edges each candidate receive rate is held, and it is also the loss window once settled. `QUAL_CYCLES` is how many consecutive good edges are needed to accept a rate. The capability flags are expected to be static outside reset. All outputs are registered and there is no streaming data path.

Top module: `lrn_link_rate_ctrl`

## Requirements
- R1: Rate encoding is 1 = high rate, 0 = low rate. On reset the controller drives tx_rate_o to the highest supported rate and rx_rate_o to the lowest supported rate. It also drives locked_o = 0 and settled_rate_o = 0.
- R2: While locked_o is 0, tx_rate_o stays at the highest supported rate.
- R3: While unlocked, each receive rate is held for DWELL_CYCLES clock edges. After that, rx_rate_o moves to the other supported rate, and after the high rate it wraps back to the low rate, repeating until lock.
- R4: Lock occurs on the edge that completes QUAL_CYCLES consecutive edges with rx_good_i = 1 at the current receive rate. One edge with rx_good_i = 0, or a change of receive rate, restarts that count.
- R5: On lock, locked_o becomes 1, tx_rate_o takes the current receive rate and settled_rate_o reports it. These values hold while locked.
- R6: If qualification completes on the same edge that the dwell window expires, the lock wins and the receive rate does not change.
- R7: Against a peer sending at the high rate, a dual-rate node first tries low for one dwell window and then settles high. Against a low-rate peer, it settles low within the first window.
- R8: While locked, DWELL_CYCLES consecutive edges with rx_good_i = 0 return the controller to its R1 state. Any edge with rx_good_i = 1 restarts that loss count.
- R9: A node supporting one rate only keeps both selects fixed at that rate and only waits for good data. A node with neither flag set behaves as low-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cap_low_i | input | 1 | Node supports the low rate |
| cap_high_i | input | 1 | Node supports the high rate |
| rx_good_i | input | 1 | Received data judged intelligible this cycle |
| tx_rate_o | output | 1 | Transmit rate select (1 = high) |
| rx_rate_o | output | 1 | Receive rate select (1 = high) |
| locked_o | output | 1 | Link has settled |
| settled_rate_o | output | 1 | Agreed rate, valid while locked_o is 1, else 0 |

## Verification
Two events can land on the same clock edge: the dwell timer running out and the qualification count completing. The bench provokes this by holding good data low for the first part of a window. It then raises good data so that the last qualifying edge is exactly the final edge of the low-rate window. The check passes only if the controller locks at the low rate: rx_rate_o must not step to high, and tx_rate_o and settled_rate_o must both read low on that edge.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

  typedef enum logic [0:0] {
    RATE_LOW  = 1'b0,
    RATE_HIGH = 1'b1
  } rate_e;

  typedef enum logic [0:0] {
    ST_SEARCH = 1'b0,
    ST_HOLD   = 1'b1
  } neg_state_e;

  // Fastest supported rate; no capability at all falls back to low.
  function automatic logic top_rate(input logic cap_lo, input logic cap_hi);
    return cap_hi;
  endfunction

  // Slowest supported rate, tried first in the search.
  function automatic logic base_rate(input logic cap_lo, input logic cap_hi);
    return cap_hi & ~cap_lo;
  endfunction

endpackage

// File: rtl/lrn_rate_planner.sv
module lrn_rate_planner
  import lrn_pkg::*;
(
  input  logic cap_lo_i,
  input  logic cap_hi_i,
  input  logic cur_rx_i,
  output logic top_o,
  output logic first_o,
  output logic next_o
);

  logic dual;

  always_comb begin
    dual    = cap_lo_i & cap_hi_i;
    top_o   = top_rate(cap_lo_i, cap_hi_i);
    first_o = base_rate(cap_lo_i, cap_hi_i);
    // Dual-rate nodes alternate; single-rate nodes stay put.
    next_o  = dual ? ~cur_rx_i : first_o;
  end

endmodule

// File: rtl/lrn_run_counter.sv
module lrn_run_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clear_i,
  input  logic step_i,
  output logic done_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] count_q;
  logic          at_last;

  always_comb begin
    at_last = (count_q == LAST);
    done_o  = step_i & at_last;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      count_q <= '0;
    end else if (step_i) begin
      count_q <= at_last ? '0 : count_q + 1'b1;
    end
  end

endmodule

// File: rtl/lrn_link_rate_ctrl.sv
module lrn_link_rate_ctrl
  import lrn_pkg::*;
#(
  parameter int DWELL_CYCLES = 64,
  parameter int QUAL_CYCLES  = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cap_low_i,
  input  logic cap_high_i,
  input  logic rx_good_i,
  output logic tx_rate_o,
  output logic rx_rate_o,
  output logic locked_o,
  output logic settled_rate_o
);

  neg_state_e state_q;
  logic       tx_q;
  logic       rx_q;
  logic       settled_q;

  logic       rate_top;
  logic       rate_first;
  logic       rate_next;

  logic       searching;
  logic       tmr_clear;
  logic       tmr_step;
  logic       tmr_done;
  logic       qual_clear;
  logic       qual_step;
  logic       qual_done;

  lrn_rate_planner u_plan (
    .cap_lo_i (cap_low_i),
    .cap_hi_i (cap_high_i),
    .cur_rx_i (rx_q),
    .top_o    (rate_top),
    .first_o  (rate_first),
    .next_o   (rate_next)
  );

  always_comb begin
    searching = (state_q == ST_SEARCH);
    // One counter serves as dwell timer while searching and loss timer when held.
    tmr_step  = searching ? 1'b1 : ~rx_good_i;
    tmr_clear = searching ? qual_done : rx_good_i;
    qual_step  = searching & rx_good_i;
    qual_clear = ~rx_good_i | ~searching | tmr_done;
  end

  lrn_run_counter #(.LIMIT(DWELL_CYCLES)) u_dwell (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clear_i (tmr_clear),
    .step_i  (tmr_step),
    .done_o  (tmr_done)
  );

  lrn_run_counter #(.LIMIT(QUAL_CYCLES)) u_qual (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clear_i (qual_clear),
    .step_i  (qual_step),
    .done_o  (qual_done)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_SEARCH;
      tx_q      <= rate_top;
      rx_q      <= rate_first;
      settled_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SEARCH: begin
          if (qual_done) begin
            // Qualification has priority over dwell expiry.
            state_q   <= ST_HOLD;
            tx_q      <= rx_q;
            settled_q <= rx_q;
          end else begin
            tx_q <= rate_top;
            if (tmr_done) rx_q <= rate_next;
          end
        end
        ST_HOLD: begin
          if (tmr_done) begin
            state_q   <= ST_SEARCH;
            tx_q      <= rate_top;
            rx_q      <= rate_first;
            settled_q <= 1'b0;
          end
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  assign tx_rate_o      = tx_q;
  assign rx_rate_o      = rx_q;
  assign locked_o       = (state_q == ST_HOLD);
  assign settled_rate_o = settled_q;

endmodule

// File: rtl/lrn_link_rate_ctrl_chk.sv
module lrn_link_rate_ctrl_chk (
  input logic clk_i,
  input logic rst_i,
  input logic cap_low_i,
  input logic cap_high_i,
  input logic rx_good_i,
  input logic tx_rate_o,
  input logic rx_rate_o,
  input logic locked_o,
  input logic settled_rate_o,
  input logic tmr_done
);

  a_r2_tx_top_while_search: assert property (@(posedge clk_i) disable iff (rst_i)
    !locked_o |-> (tx_rate_o == cap_high_i));

  a_r3_step_on_dwell_end: assert property (@(posedge clk_i) disable iff (rst_i)
    (!locked_o && $past(!locked_o) && (rx_rate_o != $past(rx_rate_o))) |-> $past(tmr_done));

  a_r4_lock_needs_good: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(locked_o) |-> $past(rx_good_i));

  a_r5_tx_follows_rx: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_o |-> (tx_rate_o == rx_rate_o) && (settled_rate_o == rx_rate_o));

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    (locked_o && $past(locked_o)) |-> $stable(rx_rate_o));

  a_r8_drop_needs_bad: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(locked_o) |-> !$past(rx_good_i));

  a_r9_single_rate_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cap_low_i && cap_high_i) |-> (rx_rate_o == cap_high_i) && (tx_rate_o == cap_high_i));

endmodule

bind lrn_link_rate_ctrl lrn_link_rate_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .cap_low_i      (cap_low_i),
  .cap_high_i     (cap_high_i),
  .rx_good_i      (rx_good_i),
  .tx_rate_o      (tx_rate_o),
  .rx_rate_o      (rx_rate_o),
  .locked_o       (locked_o),
  .settled_rate_o (settled_rate_o),
  .tmr_done       (tmr_done)
);

// File: tb/lrn_link_rate_ctrl_tb.sv
module lrn_link_rate_ctrl_tb;

  localparam int DWELL = 16;
  localparam int QUAL  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_lo = 1'b1;
  logic cap_hi = 1'b1;
  logic good = 1'b0;
  logic tx_rate, rx_rate, locked, settled;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  lrn_link_rate_ctrl #(.DWELL_CYCLES(DWELL), .QUAL_CYCLES(QUAL)) u_dut (
    .clk_i          (clk),
    .rst_i          (rst),
    .cap_low_i      (cap_lo),
    .cap_high_i     (cap_hi),
    .rx_good_i      (good),
    .tx_rate_o      (tx_rate),
    .rx_rate_o      (rx_rate),
    .locked_o       (locked),
    .settled_rate_o (settled)
  );

  // {cap_lo, cap_hi, peer_on, peer_rate, exp_lock, exp_rate, exp_edge[7:0]}
  localparam logic [13:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd20},  // R7 dual vs high peer
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd4},   // R7 dual vs low peer
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd4},   // R9 high only
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd4},   // R9 low only
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},   // R3 silent peer
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0},   // R9 high only vs low peer
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0}    // R9 low only vs high peer
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lo, input logic hi);
    rst = 1'b1;
    good = 1'b0;
    cap_lo = lo;
    cap_hi = hi;
    tick(3);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state, dual-rate
    do_reset(1'b1, 1'b1);
    chk("R1 tx", tx_rate, 1);
    chk("R1 rx", rx_rate, 0);
    chk("R1 locked", locked, 0);
    chk("R1 settled", settled, 0);
    do_reset(1'b0, 1'b1);
    chk("R9 reset rx high-only", rx_rate, 1);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      logic [13:0] e;
      int lock_edge;
      bit tx_ok;
      e = VEC[v];
      do_reset(e[13], e[12]);
      lock_edge = 0;
      tx_ok = 1'b1;
      good = e[11] && (rx_rate == e[10]);
      for (int k = 1; k <= 100; k++) begin
        tick();
        if (locked && lock_edge == 0) lock_edge = k;
        if (!locked && tx_rate != e[12]) tx_ok = 1'b0;
        good = e[11] && (rx_rate == e[10]);
      end
      chk("R7 lock edge", lock_edge, e[9] ? int'(e[7:0]) : 0);
      chk("R2 tx highest while searching", tx_ok, 1);
      if (e[9]) begin
        chk("R5 tx at settled", tx_rate, e[8]);
        chk("R5 settled rate", settled, e[8]);
      end else begin
        chk("R2 tx after search", tx_rate, e[12]);
      end
    end

    // R3 dwell and wrap
    do_reset(1'b1, 1'b1);
    tick(15);
    chk("R3 rx before dwell end", rx_rate, 0);
    tick(1);
    chk("R3 rx after dwell", rx_rate, 1);
    tick(15);
    chk("R3 rx second window", rx_rate, 1);
    tick(1);
    chk("R3 rx wraps to low", rx_rate, 0);

    // R4 broken qualification
    do_reset(1'b1, 1'b1);
    good = 1'b1; tick(3);
    good = 1'b0; tick(1);
    good = 1'b1; tick(3);
    chk("R4 no lock after gap", locked, 0);
    tick(1);
    chk("R4 lock on fourth run edge", locked, 1);

    // R6 collision: qualification ends on the last dwell edge
    do_reset(1'b1, 1'b1);
    tick(12);
    good = 1'b1;
    tick(3);
    chk("R6 not yet locked", locked, 0);
    tick(1);
    chk("R6 locked", locked, 1);
    chk("R6 rx kept low", rx_rate, 0);
    chk("R6 tx low", tx_rate, 0);
    chk("R6 settled low", settled, 0);

    // R8 loss of good data
    tick(2);
    good = 1'b0; tick(10);
    good = 1'b1; tick(1);
    good = 1'b0; tick(15);
    chk("R8 still locked", locked, 1);
    tick(1);
    chk("R8 unlocked", locked, 0);
    chk("R8 tx back to highest", tx_rate, 1);
    chk("R8 rx back to lowest", rx_rate, 0);
    chk("R8 settled cleared", settled, 0);

    // R9 neither flag: low-only
    do_reset(1'b0, 1'b0);
    tick(40);
    chk("R9 none rx", rx_rate, 0);
    chk("R9 none tx", tx_rate, 0);
    good = 1'b1;
    tick(4);
    chk("R9 none locks low", locked, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule